// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This is a register-mapped 16-bit down-counting timer for use as a system tick or a delay source. Software writes a start count, sets a control word, and the counter steps down once per prescaled tick. The prescaler can pass the input clock straight through or divide it by 16 or by 256. The timer runs in one of two modes. In periodic mode it reloads from the start count after it reaches zero and keeps running. In one-shot mode it stops at zero and drops its own enable.

When the count steps from one to zero, a pending flag is set. That flag drives a level interrupt through an interrupt-enable gate. The flag stays set until software writes to the clear register. The bus is a simple single-cycle port with word addressing. Writes take effect at the clock edge where they are presented. Reads are combinational from the currently addressed register.

Top module: `countdown_timer`

## Requirements
- R1: After reset the value register reads 0xFFFF, the load register reads 0, the control register reads 0 and `irqOut` is low.
- R2: Register map by word address: 0 is load (read/write, low 16 bits), 1 is the current value (read-only, writes have no effect), 2 is control, and 3 is interrupt clear (write-only, reads 0). In the control word, bit 7 is enable, bit 6 is periodic, bit 5 is interrupt enable and bits 3:2 are prescale. The other control bits read 0.
- R3: While enable is clear the value register does not change, except by a load write.
- R4: Prescale code 00 or 11 gives a tick every cycle, 01 one every 16 cycles and 10 one every 256 cycles. Any load or control write restarts the prescaler, so the first decrement after an enabling control write lands N cycles after that write, where N is the divide ratio.
- R5: A load write sets both the load register and the current value to the written value at that same edge. It also restarts the prescaler, even in the middle of a count.
- R6: In periodic mode a tick that finds the count at zero reloads it from the load register, and enable stays set.
- R7: In one-shot mode the tick that takes the count to zero clears enable, and the count then stays at zero. A control write in the same cycle takes priority over this clear.
- R8: A tick that takes the count from 1 to 0 sets the pending flag. `irqOut` equals the pending flag ANDed with the interrupt-enable bit, so interrupt enable gates the output line but not the flag.
- R9: Any write to word address 3 clears the pending flag. If an expiry falls in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (2) | Word address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data of the addressed register (combinational) |
| irqOut | output | 1 | Level interrupt: pending flag AND interrupt enable |

## Verification
A write changes its register at the edge where it is presented. The read mux and `irqOut` are combinational, so both show the new state in the half cycle after that edge. A decrement happens at the N-th edge after the enabling write, and the bench reads just before that edge and again just before the next to see both sides of the step. A behavioural model advances at each rising edge. Its state is compared with the read data and `irqOut` one nanosecond after each falling edge, once all inputs for the next edge are stable. The set-wins case is timed by landing the clear write on exactly the third tick of a periodic /1 count of three.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // word addresses of the registers
  localparam logic [1:0] WA_LOAD  = 2'd0;
  localparam logic [1:0] WA_VALUE = 2'd1;
  localparam logic [1:0] WA_CTRL  = 2'd2;
  localparam logic [1:0] WA_CLEAR = 2'd3;

  // control word bit positions
  localparam int CB_ENABLE   = 7;
  localparam int CB_PERIODIC = 6;
  localparam int CB_IRQEN    = 5;
  localparam int CB_PS_LO    = 2;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_SPARE  = 2'b11
  } psSel_e;

  // strobes and settings sent from control to datapath
  typedef struct packed {
    logic   loadWr;
    logic   psRestart;
    logic   enable;
    logic   periodic;
    psSel_e psSel;
  } ctlStrobe_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_SHIFT_LO = 4,
  parameter int PS_SHIFT_HI = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] valueQ,
  output logic [CNT_W-1:0] loadQ,
  output logic             tickEvt,
  output logic             expireEvt,
  output logic             stopEvt
);
  localparam int PS_W = PS_SHIFT_HI;
  localparam logic [PS_W-1:0] LIM_LO = PS_W'((1 << PS_SHIFT_LO) - 1);
  localparam logic [PS_W-1:0] LIM_HI = '1;
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psLimit;
  logic            atOne;
  logic            atZero;
  logic            countTick;

  always_comb begin
    unique case (strb.psSel)
      PS_DIV16:  psLimit = LIM_LO;
      PS_DIV256: psLimit = LIM_HI;
      default:   psLimit = '0;
    endcase
  end

  assign tickEvt   = strb.enable && (psCnt == psLimit);
  assign countTick = tickEvt && !strb.loadWr;
  assign atOne     = (valueQ == ONE);
  assign atZero    = (valueQ == '0);
  assign expireEvt = countTick && atOne;
  assign stopEvt   = countTick && !strb.periodic && (atOne || atZero);

  // prescaler: restarts on register writes or while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (!strb.enable || strb.psRestart || tickEvt) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ <= '0;
    end else if (strb.loadWr) begin
      loadQ <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ <= '1;
    end else if (strb.loadWr) begin
      valueQ <= loadData;
    end else if (tickEvt) begin
      if (!atZero) begin
        valueQ <= valueQ - 1'b1;
      end else if (strb.periodic) begin
        valueQ <= loadQ;
      end
    end
  end
endmodule

// File: rtl/timer_control.sv
module timer_control
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  valueQ,
  input  logic [CNT_W-1:0]  loadQ,
  input  logic              expireEvt,
  input  logic              stopEvt,
  output ctlStrobe_t        strb,
  output logic              pendQ,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  logic   wrLoad, wrCtrl, wrClear;
  logic   enQ, perQ, ienQ;
  psSel_e psQ;
  logic   unusedWdata;

  assign wrLoad  = busSel && busWr && (busAddr == WA_LOAD);
  assign wrCtrl  = busSel && busWr && (busAddr == WA_CTRL);
  assign wrClear = busSel && busWr && (busAddr == WA_CLEAR);

  assign unusedWdata = ^{busWdata[DATA_W-1:CB_ENABLE+1], busWdata[CB_PS_LO+2],
                         busWdata[CB_PS_LO-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      perQ <= 1'b0;
      ienQ <= 1'b0;
      psQ  <= PS_DIV1;
    end else if (wrCtrl) begin
      enQ  <= busWdata[CB_ENABLE];
      perQ <= busWdata[CB_PERIODIC];
      ienQ <= busWdata[CB_IRQEN];
      psQ  <= psSel_e'(busWdata[CB_PS_LO+1:CB_PS_LO]);
    end else if (stopEvt) begin
      enQ  <= 1'b0;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (expireEvt) begin
      pendQ <= 1'b1;
    end else if (wrClear) begin
      pendQ <= 1'b0;
    end
  end

  always_comb begin
    strb.loadWr    = wrLoad;
    strb.psRestart = wrLoad || wrCtrl;
    strb.enable    = enQ;
    strb.periodic  = perQ;
    strb.psSel     = psQ;
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      WA_LOAD:  busRdata = DATA_W'(loadQ);
      WA_VALUE: busRdata = DATA_W'(valueQ);
      WA_CTRL: begin
        busRdata[CB_ENABLE]                = enQ;
        busRdata[CB_PERIODIC]              = perQ;
        busRdata[CB_IRQEN]                 = ienQ;
        busRdata[CB_PS_LO+1:CB_PS_LO]      = psQ;
      end
      default:  busRdata = '0;
    endcase
  end

  assign irqOut = pendQ && ienQ;
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int PS_SHIFT_LO = 4,
  parameter int PS_SHIFT_HI = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  ctlStrobe_t       strb;
  logic [CNT_W-1:0] valueQ;
  logic [CNT_W-1:0] loadQ;
  logic             tickEvt, expireEvt, stopEvt, pendQ;

  timer_control #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .valueQ(valueQ), .loadQ(loadQ),
    .expireEvt(expireEvt), .stopEvt(stopEvt),
    .strb(strb), .pendQ(pendQ),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  timer_datapath #(
    .CNT_W(CNT_W), .PS_SHIFT_LO(PS_SHIFT_LO), .PS_SHIFT_HI(PS_SHIFT_HI)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .loadData(busWdata[CNT_W-1:0]),
    .valueQ(valueQ), .loadQ(loadQ),
    .tickEvt(tickEvt), .expireEvt(expireEvt), .stopEvt(stopEvt)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input ctlStrobe_t        strb,
  input logic [CNT_W-1:0]  valueQ,
  input logic [CNT_W-1:0]  loadQ,
  input logic              tickEvt,
  input logic              expireEvt,
  input logic              pendQ
);
  logic ctrlWrite, clearWrite;
  assign ctrlWrite  = busSel && busWr && (busAddr == WA_CTRL);
  assign clearWrite = busSel && busWr && (busAddr == WA_CLEAR);

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enable && !strb.loadWr) |=> $stable(valueQ));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt && !strb.loadWr && valueQ != '0) |=> (valueQ == $past(valueQ) - 1'b1));

  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> (valueQ == $past(busWdata[CNT_W-1:0])));

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt && !strb.loadWr && valueQ == '0 && strb.periodic) |=>
      (valueQ == $past(loadQ)));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt && !strb.loadWr && !strb.periodic && valueQ == CNT_W'(1) && !ctrlWrite)
      |=> !strb.enable);

  assert_pending_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    expireEvt |=> pendQ);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendQ);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearWrite && !expireEvt) |=> !pendQ);
endmodule

bind countdown_timer timer_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_checker (
  .clk(clk), .rstN(rstN),
  .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .irqOut(irqOut), .strb(strb), .valueQ(valueQ), .loadQ(loadQ),
  .tickEvt(tickEvt), .expireEvt(expireEvt), .pendQ(pendQ)
);

// File: tb/test_countdown_timer.sv
`timescale 1ns/1ps
module test_countdown_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int mLoad, mValue, mPs;
  bit mEn, mPer, mIen, mPend;
  int mPsSel;

  always #2 clk = ~clk;

  countdown_timer i_countdown_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelRead(input int a);
    case (a)
      0: return mLoad;
      1: return mValue;
      2: return (int'(mEn) << 7) | (int'(mPer) << 6) | (int'(mIen) << 5) | (mPsSel << 2);
      default: return 0;
    endcase
  endfunction

  // reference model advances at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mLoad = 0; mValue = 16'hFFFF; mPs = 0;
      mEn = 0; mPer = 0; mIen = 0; mPend = 0; mPsSel = 0;
    end else begin
      int lim, a, d;
      bit wl, wc, wx, tick, expire, stop;
      a = int'(busAddr); d = int'(busWdata);
      wl = busSel && busWr && a == 0;
      wc = busSel && busWr && a == 2;
      wx = busSel && busWr && a == 3;
      lim = (mPsSel == 1) ? 15 : (mPsSel == 2) ? 255 : 0;
      tick = mEn && (mPs == lim);
      expire = tick && !wl && mValue == 1;
      stop = tick && !wl && !mPer && mValue <= 1;
      if (!mEn || wl || wc || tick) mPs = 0; else mPs = mPs + 1;
      if (wl) begin
        mValue = d & 16'hFFFF; mLoad = d & 16'hFFFF;
      end else if (tick) begin
        if (mValue != 0) mValue = mValue - 1;
        else if (mPer) mValue = mLoad;
      end
      if (wc) begin
        mEn = d[7]; mPer = d[6]; mIen = d[5]; mPsSel = (d >> 2) & 3;
      end else if (stop) mEn = 0;
      if (expire) mPend = 1; else if (wx) mPend = 0;
    end
  end

  // per-cycle comparison, after inputs for the next edge have settled
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      check(busRdata == 32'(modelRead(int'(busAddr))), "R2/R5 model readback",
            busRdata, modelRead(int'(busAddr)));
      check(irqOut == (mPend && mIen), "R8 model irq", irqOut, mPend && mIen);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = 32'd0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = 2'(a);
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(0, r); check(r == 0, "R1 load", r, 0);
    rd(1, r); check(r == 32'hFFFF, "R1 value", r, 32'hFFFF);
    rd(2, r); check(r == 0, "R1 ctrl", r, 0);
    check(irqOut == 0, "R1 irq", irqOut, 0);
    // R2 value register ignores writes; control reserved bits read 0
    wr(1, 32'h1234);
    rd(1, r); check(r == 32'hFFFF, "R2 value write ignored", r, 32'hFFFF);
    wr(2, 32'hFFFF_FF6C);
    rd(2, r); check(r == 32'h6C, "R2 ctrl readback", r, 32'h6C);
    // R3 no counting while disabled
    idle(20);
    rd(1, r); check(r == 32'hFFFF, "R3 held while disabled", r, 32'hFFFF);
    wr(2, 0);
    wr(0, 32'h10);
    rd(1, r); check(r == 32'h10, "R5 load sets value", r, 32'h10);
    // R4 divide by 1, one-shot
    wr(2, 32'h80);
    rd(1, r); check(r == 32'h10, "R4 /1 before first tick", r, 32'h10);
    rd(1, r); check(r == 32'h0F, "R4 /1 first tick", r, 32'h0F);
    idle(30);
    rd(1, r); check(r == 0, "R7 one-shot stays at zero", r, 0);
    rd(2, r); check(r == 0, "R7 enable cleared", r, 0);
    check(irqOut == 0, "R8 gated by irq enable", irqOut, 0);
    wr(2, 32'h20);
    check(irqOut == 1, "R8 pending shown when enabled", irqOut, 1);
    wr(3, 0);
    check(irqOut == 0, "R9 clear", irqOut, 0);
    // R5 restart in mid count
    wr(0, 32'h40);
    wr(2, 32'h80);
    idle(5);
    wr(0, 32'h30);
    rd(1, r); check(r == 32'h30, "R5 mid-count restart", r, 32'h30);
    wr(2, 0);
    // R4 divide by 16
    wr(0, 3);
    wr(2, 32'hA4);
    idle(15);
    rd(1, r); check(r == 3, "R4 /16 before tick", r, 3);
    rd(1, r); check(r == 2, "R4 /16 first tick", r, 2);
    idle(100);
    check(irqOut == 1, "R8 /16 expiry", irqOut, 1);
    wr(3, 0);
    wr(2, 0);
    // R4 divide by 256, periodic
    wr(0, 2);
    wr(2, 32'hE8);
    idle(255);
    rd(1, r); check(r == 2, "R4 /256 before tick", r, 2);
    rd(1, r); check(r == 1, "R4 /256 first tick", r, 1);
    idle(600);
    rd(2, r); check(r == 32'hE8, "R6 periodic keeps enable", r, 32'hE8);
    check(irqOut == 1, "R8 periodic expiry", irqOut, 1);
    wr(2, 0);
    wr(3, 0);
    // R9 set wins over clear in the same cycle
    wr(0, 3);
    wr(2, 32'hE0);
    idle(2);
    wr(3, 0);
    check(irqOut == 1, "R9 set wins", irqOut, 1);
    wr(3, 0);
    check(irqOut == 0, "R9 clear after", irqOut, 0);
    rd(1, r); check(r == 3, "R6 reload from load", r, 3);
    wr(2, 0);
    // R3 stopped counter holds
    rd(1, r);
    idle(10);
    rd(1, r2); check(r2 == r, "R3 stable after disable", r2, r);
    finished = 1;
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule